// File: doc/BRIEF.md
# Double-Pumped Four-Port Memory

This block gives logic on a core clock a memory with four read/write ports that all work in every core cycle. It holds one two-port storage array and clocks it at twice the core rate. Each physical port of the array serves two logical ports, one after the other, inside each core cycle. An input multiplexer picks the requester for each half-cycle. A set of return registers steers each read result back to the logical port that asked for it.

The fast clock must run at exactly twice the core clock, with its rising edges landing on every core rising edge. Because both clocks share one source, no asynchronous crossing logic is used. Requests are registered on the core clock and held for both fast half-cycles. Read results return to the core domain with a fixed latency.

Ports 0 and 1 share physical port 0, and ports 2 and 3 share physical port 1. In each core cycle the first half serves ports 0 and 2, and the second half serves ports 1 and 3. This order decides the result whenever two requests in one cycle touch the same word.

Top module: `quad_port_ram`

## Requirements
- R1: While rstN is low, all four read-data outputs are zero.
- R2: Address and write data presented at core edge n take effect in that core cycle. The word read at edge n appears on portRdata from edge n+2 and holds for one full core cycle. A word written at edge n is read back by a read issued at edge n+1 or later.
- R3: All four logical ports complete one independent read and, when enabled, one write in every core cycle, with any mix of addresses.
- R4: Ports 0 and 2 are served in the first fast half of each core cycle, and ports 1 and 3 in the second half. When port 0 and port 1 write the same address in one core cycle, port 1's data remains. When port 2 and port 3 do so, port 3's data remains.
- R5: When the two ports served in the same half both write one address, the port on physical port 1 wins. So port 2 wins over port 0, and port 3 wins over port 1.
- R6: A read served in the same half as a write to its address returns the contents from before that write. This applies both to the port's own write and to a write on the other physical port.
- R7: A read served in the second half returns data written to its address in the first half of the same core cycle.
- R8: A port whose write enable is low does not change the memory, whatever its write data and address are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkCore | input | 1 | Core clock, the rate at which the four ports are used |
| clkFast | input | 1 | Storage clock at twice the core rate, rising edges aligned with clkCore |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| portWe | input | 4 | Per-port write enable, bit k for logical port k |
| portAddr | input | 4 x ADDR_W | Per-port word address |
| portWdata | input | 4 x DATA_W | Per-port write data |
| portRdata | output | 4 x DATA_W | Per-port read data, valid two core cycles after the request |

## Verification
The hardest case to reach from the ports is a set of same-cycle collisions, because the outcome depends on the hidden half-cycle order. Such collisions include two writes to one word, and a read that races a write on the other physical port. The stimulus aims several ports at one address in one core cycle, for each pairing of logical ports, and then reads the word back in a quiet cycle. A later phase confines pseudo-random addresses to eight words, so that collisions of every kind occur densely. A reference model applies the first-half reads, then the first-half writes, then the second-half reads, then the second-half writes, and predicts each returned word.

// File: rtl/qpr_pkg.sv
package qpr_pkg;
  localparam int LOG_PORTS  = 4;
  localparam int PHYS_PORTS = 2;

  // Half-cycle strobes handed from the phase control to the datapath.
  typedef struct packed {
    logic serveA;  // first fast half of the core cycle: ports 0 and 2
    logic serveB;  // second fast half of the core cycle: ports 1 and 3
  } qprStrobe_t;
endpackage

// File: rtl/qpr_phase_ctrl.sv
module qpr_phase_ctrl
  import qpr_pkg::*;
(
  input  logic       clkCore,
  input  logic       clkFast,
  input  logic       rstN,
  output qprStrobe_t strobe
);
  logic coreToggle;
  logic fastSeen;

  // Toggles once per core cycle.
  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN) coreToggle <= 1'b0;
    else       coreToggle <= ~coreToggle;
  end

  // Follows the toggle one fast edge later, so the two differ only in the
  // first fast half after each core edge.
  always_ff @(posedge clkFast or negedge rstN) begin
    if (!rstN) fastSeen <= 1'b0;
    else       fastSeen <= coreToggle;
  end

  always_comb begin
    strobe.serveA = coreToggle ^ fastSeen;
    strobe.serveB = ~(coreToggle ^ fastSeen);
  end
endmodule

// File: rtl/qpr_datapath.sv
module qpr_datapath
  import qpr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic                                clkCore,
  input  logic                                clkFast,
  input  logic                                rstN,
  input  qprStrobe_t                          strobe,
  input  logic [LOG_PORTS-1:0]                portWe,
  input  logic [LOG_PORTS-1:0][ADDR_W-1:0]    portAddr,
  input  logic [LOG_PORTS-1:0][DATA_W-1:0]    portWdata,
  output logic [LOG_PORTS-1:0][DATA_W-1:0]    portRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // Core-side request registers, steady across both fast halves.
  logic [LOG_PORTS-1:0]             reqWe;
  logic [LOG_PORTS-1:0][ADDR_W-1:0] reqAddr;
  logic [LOG_PORTS-1:0][DATA_W-1:0] reqData;

  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN) begin
      reqWe   <= '0;
      reqAddr <= '0;
      reqData <= '0;
    end else begin
      reqWe   <= portWe;
      reqAddr <= portAddr;
      reqData <= portWdata;
    end
  end

  // Input multiplexers: physical port p serves logical 2p, then 2p+1.
  logic [PHYS_PORTS-1:0]             physWe;
  logic [PHYS_PORTS-1:0][ADDR_W-1:0] physAddr;
  logic [PHYS_PORTS-1:0][DATA_W-1:0] physData;

  always_comb begin
    for (int p = 0; p < PHYS_PORTS; p++) begin
      if (strobe.serveB) begin
        physWe[p]   = reqWe[2*p+1];
        physAddr[p] = reqAddr[2*p+1];
        physData[p] = reqData[2*p+1];
      end else begin
        physWe[p]   = reqWe[2*p];
        physAddr[p] = reqAddr[2*p];
        physData[p] = reqData[2*p];
      end
    end
  end

  // Storage array: the later loop index overrides, so physical port 1 wins.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clkFast) begin
    for (int p = 0; p < PHYS_PORTS; p++) begin
      if (physWe[p]) mem[physAddr[p]] <= physData[p];
    end
  end

  // Return path per physical port.
  for (genvar g = 0; g < PHYS_PORTS; g++) begin : g_ret
    logic [DATA_W-1:0] capA;
    logic [DATA_W-1:0] heldA;
    logic [DATA_W-1:0] heldB;
    logic [DATA_W-1:0] outA;
    logic [DATA_W-1:0] outB;

    // The first-half read is parked. At the end of the second half both
    // results move together into a pair that is stable for a core cycle.
    always_ff @(posedge clkFast or negedge rstN) begin
      if (!rstN) begin
        capA  <= '0;
        heldA <= '0;
        heldB <= '0;
      end else if (strobe.serveA) begin
        capA  <= mem[physAddr[g]];
      end else begin
        heldA <= capA;
        heldB <= mem[physAddr[g]];
      end
    end

    always_ff @(posedge clkCore or negedge rstN) begin
      if (!rstN) begin
        outA <= '0;
        outB <= '0;
      end else begin
        outA <= heldA;
        outB <= heldB;
      end
    end

    assign portRdata[2*g]   = outA;
    assign portRdata[2*g+1] = outB;
  end
endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram
  import qpr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic                             clkCore,
  input  logic                             clkFast,
  input  logic                             rstN,
  input  logic [3:0]                       portWe,
  input  logic [3:0][ADDR_W-1:0]           portAddr,
  input  logic [3:0][DATA_W-1:0]           portWdata,
  output logic [3:0][DATA_W-1:0]           portRdata
);
  qprStrobe_t strobe;

  qpr_phase_ctrl uCtrl (
    .clkCore (clkCore),
    .clkFast (clkFast),
    .rstN    (rstN),
    .strobe  (strobe)
  );

  qpr_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uPath (
    .clkCore   (clkCore),
    .clkFast   (clkFast),
    .rstN      (rstN),
    .strobe    (strobe),
    .portWe    (portWe),
    .portAddr  (portAddr),
    .portWdata (portWdata),
    .portRdata (portRdata)
  );
endmodule

// File: rtl/qpr_checker.sv
module qpr_checker
  import qpr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input logic                   clkCore,
  input logic                   clkFast,
  input logic                   rstN,
  input qprStrobe_t             strobe,
  input logic [3:0]             portWe,
  input logic [3:0][ADDR_W-1:0] portAddr,
  input logic [3:0][DATA_W-1:0] portWdata,
  input logic [3:0][DATA_W-1:0] portRdata
);
  // R1
  always @(negedge clkFast) begin
    if (!rstN) begin
      rst_zero_chk: assert (portRdata == '0);
    end
  end

  // R4
  phase_a_then_b_chk: assert property (@(posedge clkFast) disable iff (!rstN)
    strobe.serveA |=> strobe.serveB);

  // R4
  phase_b_then_a_chk: assert property (@(posedge clkFast) disable iff (!rstN)
    strobe.serveB |=> strobe.serveA);

  for (genvar k = 0; k < 4; k++) begin : g_lat
    // R2
    port_latency_chk: assert property (@(posedge clkCore) disable iff (!rstN)
      ($past(portWe, 4) == (4'b0001 << k)) && ($past(portWe, 3) == 4'b0000) &&
      ($past(portAddr[k], 3) == $past(portAddr[k], 4))
      |-> portRdata[k] == $past(portWdata[k], 4));
  end

  for (genvar g = 0; g < 2; g++) begin : g_phys
    // R4
    same_phys_order_chk: assert property (@(posedge clkCore) disable iff (!rstN)
      ($past(portWe, 4) == (4'b0011 << (2*g))) &&
      ($past(portAddr[2*g], 4) == $past(portAddr[2*g+1], 4)) &&
      ($past(portWe, 3) == 4'b0000) &&
      ($past(portAddr[2*g], 3) == $past(portAddr[2*g], 4))
      |-> portRdata[2*g] == $past(portWdata[2*g+1], 4));

    // R5
    cross_phys_order_chk: assert property (@(posedge clkCore) disable iff (!rstN)
      ($past(portWe, 4) == (4'b0101 << g)) &&
      ($past(portAddr[g], 4) == $past(portAddr[g+2], 4)) &&
      ($past(portWe, 3) == 4'b0000) &&
      ($past(portAddr[g], 3) == $past(portAddr[g], 4))
      |-> portRdata[g] == $past(portWdata[g+2], 4));
  end

  // R7
  phase_b_sees_a_chk: assert property (@(posedge clkCore) disable iff (!rstN)
    ($past(portWe, 3) == 4'b0001) && ($past(portAddr[1], 3) == $past(portAddr[0], 3))
    |-> portRdata[1] == $past(portWdata[0], 3));
endmodule

bind quad_port_ram qpr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clkCore   (clkCore),
  .clkFast   (clkFast),
  .rstN      (rstN),
  .strobe    (strobe),
  .portWe    (portWe),
  .portAddr  (portAddr),
  .portWdata (portWdata),
  .portRdata (portRdata)
);

// File: tb/test_quad_port_ram.sv
module test_quad_port_ram;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW    = 16;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic               clkCore = 1'b0;
  logic               clkFast = 1'b1;
  logic               rstN    = 1'b0;
  logic [3:0]         portWe    = '0;
  logic [3:0][AW-1:0] portAddr  = '0;
  logic [3:0][DW-1:0] portWdata = '0;
  logic [3:0][DW-1:0] portRdata;

  always #5   clkCore = ~clkCore;
  always #2.5 clkFast = ~clkFast;

  quad_port_ram #(.DATA_W(DW), .ADDR_W(AW)) i_quad_port_ram (
    .clkCore   (clkCore),
    .clkFast   (clkFast),
    .rstN      (rstN),
    .portWe    (portWe),
    .portAddr  (portAddr),
    .portWdata (portWdata),
    .portRdata (portRdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clkCore) cyc++;

  // Reference model and scoreboard queues.
  logic [DW-1:0] model [DEPTH];
  bit            known [DEPTH];

  int                 stampQ[$];
  logic [3:0]         maskQ[$];
  logic [3:0][DW-1:0] expQ[$];
  string              tagQ[$];

  function automatic logic [3:0][AW-1:0] mkA(int a0, int a1, int a2, int a3);
    logic [3:0][AW-1:0] r;
    r[0] = AW'(a0); r[1] = AW'(a1); r[2] = AW'(a2); r[3] = AW'(a3);
    return r;
  endfunction

  function automatic logic [3:0][DW-1:0] mkD(int d0, int d1, int d2, int d3);
    logic [3:0][DW-1:0] r;
    r[0] = DW'(d0); r[1] = DW'(d1); r[2] = DW'(d2); r[3] = DW'(d3);
    return r;
  endfunction

  // Driver: presents one core cycle of requests and predicts the reads.
  task automatic issue(input logic [3:0] we, input logic [3:0][AW-1:0] a,
                       input logic [3:0][DW-1:0] d, input logic [3:0] chk,
                       input string tag);
    logic [3:0][DW-1:0] e;
    logic [3:0]         m;
    @(negedge clkCore);
    portWe    = we;
    portAddr  = a;
    portWdata = d;
    // First half: ports 0 and 2 read, then write (port 2 after port 0).
    e[0] = model[a[0]]; m[0] = known[a[0]];
    e[2] = model[a[2]]; m[2] = known[a[2]];
    if (we[0]) begin model[a[0]] = d[0]; known[a[0]] = 1'b1; end
    if (we[2]) begin model[a[2]] = d[2]; known[a[2]] = 1'b1; end
    // Second half: ports 1 and 3.
    e[1] = model[a[1]]; m[1] = known[a[1]];
    e[3] = model[a[3]]; m[3] = known[a[3]];
    if (we[1]) begin model[a[1]] = d[1]; known[a[1]] = 1'b1; end
    if (we[3]) begin model[a[3]] = d[3]; known[a[3]] = 1'b1; end
    stampQ.push_back(cyc);
    maskQ.push_back(m & chk);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    issue(4'b0000, mkA(0, 0, 0, 0), mkD(0, 0, 0, 0), 4'b0000, "idle");
  endtask

  // Monitor: results from the request sampled at edge n appear after edge n+2.
  initial begin
    forever begin
      @(posedge clkCore);
      #2;
      while (stampQ.size() > 0 && stampQ[0] + 3 == cyc) begin
        logic [3:0]         m;
        logic [3:0][DW-1:0] e;
        string              t;
        m = maskQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        void'(stampQ.pop_front());
        for (int p = 0; p < 4; p++) begin
          if (m[p]) begin
            checks++;
            if (portRdata[p] !== e[p]) begin
              errors++;
              $display("FAIL %s port %0d: got %h expected %h", t, p, portRdata[p], e[p]);
            end
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R2): got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr;
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;

    repeat (3) @(negedge clkCore);
    // R1: outputs held at zero while in reset
    for (int p = 0; p < 4; p++) begin
      checks++;
      if (portRdata[p] !== '0) begin
        errors++;
        $display("FAIL R1 port %0d: got %h expected %h", p, portRdata[p], {DW{1'b0}});
      end
    end
    // Release just before a core edge, so the next fast edge starts a core cycle.
    #2 rstN = 1'b1;

    // Fill the whole array, four words per cycle.
    for (int a = 0; a < DEPTH; a += 4)
      issue(4'b1111, mkA(a, a + 1, a + 2, a + 3),
            mkD(16'h1000 + a, 16'h1000 + a + 1, 16'h1000 + a + 2, 16'h1000 + a + 3),
            4'b0000, "init");

    // R2: read back one word per port per cycle, shifted per port
    for (int a = 0; a < DEPTH; a += 4)
      issue(4'b0000, mkA(a + 3, a + 2, a + 1, a), mkD(0, 0, 0, 0), 4'b1111, "R2");

    // R3: all four ports write distinct words and read others together
    issue(4'b1111, mkA(40, 41, 42, 43), mkD(16'hA0A0, 16'hA1A1, 16'hA2A2, 16'hA3A3),
          4'b0000, "R3");
    issue(4'b0101, mkA(43, 5, 41, 6), mkD(16'hC0C0, 0, 16'hC2C2, 0), 4'b1111, "R3");
    issue(4'b0000, mkA(42, 43, 40, 41), mkD(0, 0, 0, 0), 4'b1111, "R3");

    // R4: same physical port, same word: second-half port wins
    issue(4'b0011, mkA(9, 9, 0, 0), mkD(16'h0A11, 16'h0B11, 0, 0), 4'b0000, "R4");
    issue(4'b1100, mkA(0, 0, 11, 11), mkD(0, 0, 16'h2A22, 16'h2B22), 4'b0000, "R4");
    issue(4'b0000, mkA(9, 11, 11, 9), mkD(0, 0, 0, 0), 4'b1111, "R4");

    // R5: same half, both physical ports, same word: physical port 1 wins
    issue(4'b0101, mkA(13, 0, 13, 0), mkD(16'h5005, 0, 16'h5225, 0), 4'b0000, "R5");
    issue(4'b1010, mkA(0, 14, 0, 14), mkD(0, 16'h5115, 0, 16'h5335), 4'b0000, "R5");
    issue(4'b0000, mkA(13, 14, 14, 13), mkD(0, 0, 0, 0), 4'b1111, "R5");

    // R6: same-half reads see old contents (other physical port and own port)
    issue(4'b0100, mkA(20, 0, 20, 0), mkD(0, 0, 16'h6620, 0), 4'b0001, "R6");
    issue(4'b0010, mkA(0, 21, 0, 21), mkD(0, 16'h6621, 0, 0), 4'b1000, "R6");
    issue(4'b0001, mkA(22, 0, 0, 0), mkD(16'h6622, 0, 0, 0), 4'b0001, "R6");
    issue(4'b0000, mkA(20, 21, 22, 0), mkD(0, 0, 0, 0), 4'b0111, "R6");

    // R7: a second-half read sees the first-half write of the same cycle
    issue(4'b0001, mkA(30, 30, 0, 30), mkD(16'h7730, 0, 0, 0), 4'b1010, "R7");
    issue(4'b0100, mkA(0, 31, 31, 31), mkD(0, 0, 16'h7731, 0), 4'b1010, "R7");

    // R8: write data with enables low leaves the memory untouched
    issue(4'b0000, mkA(33, 34, 35, 36), mkD(16'hDEAD, 16'hBEEF, 16'hFACE, 16'hF00D),
          4'b0000, "R8");
    issue(4'b0000, mkA(36, 35, 34, 33), mkD(0, 0, 0, 0), 4'b1111, "R8");

    // R3: dense pseudo-random traffic over eight words, checked every cycle
    lfsr = 32'h1234_5678;
    for (int i = 0; i < 200; i++) begin
      logic [3:0] we;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      we = lfsr[3:0];
      issue(we, mkA(int'(lfsr[6:4]), int'(lfsr[9:7]), int'(lfsr[12:10]), int'(lfsr[15:13])),
            mkD(int'(lfsr[31:16]), int'(lfsr[31:16] ^ 16'h1111),
                int'(lfsr[31:16] ^ 16'h2222), int'(lfsr[31:16] ^ 16'h3333)),
            4'b1111, "R3");
    end

    repeat (6) idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule